// File: doc/BRIEF.md
# Chained Integer Set-Compare Unit

This unit compares two 32-bit integer operands under a selectable relation and turns the outcome into a 32-bit result word. A true outcome writes either an all-ones mask or the single-precision encoding of 1.0. A false outcome writes zero. Before the result is formed, the compare outcome is merged with a predicate bit through a selectable boolean operation. The predicate can be inverted first. If requested, the unit also refreshes a zero condition flag from the word it writes.

Two compare modes are offered. Plain mode is an ordinary signed or unsigned 32-bit comparison. Chained mode lets software build a compare wider than 32 bits from 32-bit slices. Each slice is processed from low order to high order. The carry and zero flags left by the lower-order slice enter on dedicated inputs, and they steer the decision for the current slice. All operands, flags and control fields arrive on ports. The result, the zero flag and an error pulse leave from registers one clock later.

Top module: `isc_set_cmp`

## Requirements
- R1: `cmp_sel` selects the relation by code: 0 never, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal, 7 always. With `chain_en` low, the relation is evaluated on `src_a` against `src_b`. The comparison is two's-complement when `is_signed` is 1 and unsigned otherwise, and `carry_in` and `zero_in` are ignored.
- R2: With `chain_en` high, the unit forms a difference term `d = src_a + ~src_b + carry_in` modulo 2^32. A flip term is 0 for signed compares and `src_a[31] ^ src_b[31]` for unsigned ones. The base less test is `d >= 0` as a signed value when flip is 1, and `d < 0` as a signed value otherwise. Code 1 returns this base test.
- R3: In chained mode, equal is true only when `d == 0` and `zero_in` is 1. Not-equal is true when `d != 0`, or when `d == 0` and `zero_in` is 0.
- R4: In chained mode, less-or-equal is (base less) OR (`d == 0` AND `zero_in`). Greater-or-equal is (flip ? `d < 0` : `d >= 0`) OR (`d == 0` AND `zero_in`). Greater is (flip ? `d <= 0` : `d > 0`) OR (`d == 0` AND NOT `zero_in`). All tests on `d` are signed.
- R5: The predicate is inverted when `pred_inv` is 1. It is then merged with the compare outcome as chosen by `bool_sel`: 0 AND, 1 OR, 2 XOR.
- R6: When the merged outcome is true, the result is 0xFFFFFFFF if `float_sel` is 0 and 0x3F800000 if `float_sel` is 1. When it is false, the result is 0.
- R7: An operation presented with `op_valid` high appears on `res_data` together with a one-cycle `res_valid` pulse on the following clock. With `op_valid` low, `res_valid` stays low.
- R8: A legal operation with `cc_en` high sets `zero_flag` to 1 when its result is 0 and to 0 otherwise, in the same cycle as the result. Every other cycle leaves `zero_flag` unchanged.
- R9: An operation with `bool_sel` equal to 3, or with `cc_en` and `chain_en` both high, is illegal. It raises `err_illegal` alongside its `res_valid`, writes a result of 0, and leaves `zero_flag` unchanged.
- R10: After reset, `res_valid`, `res_data`, `zero_flag` and `err_illegal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| cmp_sel | input | 3 | Relation code |
| is_signed | input | 1 | Two's-complement compare when 1 |
| chain_en | input | 1 | Chained (multi-slice) mode |
| carry_in | input | 1 | Carry left by the lower-order slice |
| zero_in | input | 1 | Zero flag left by the lower-order slice |
| pred_in | input | 1 | Predicate bit |
| pred_inv | input | 1 | Invert predicate before merging |
| bool_sel | input | 2 | Merge operation: 0 AND, 1 OR, 2 XOR |
| float_sel | input | 1 | True result is 1.0 in float form when 1 |
| cc_en | input | 1 | Refresh the zero flag |
| res_valid | output | 1 | Result present |
| res_data | output | 32 | Result word |
| zero_flag | output | 1 | Zero condition flag |
| err_illegal | output | 1 | Illegal combination flagged |

## Verification
When `cc_en` is set, the result write and the zero-flag refresh land in the same cycle. The bench provokes this with flag-updating operations whose merged outcome is alternately true and false, and with float and mask encodings. It checks that the flag matches the word produced in that same cycle. Chained mode and `cc_en` meeting in one operation form a second collision. The bench sends such operations straight after a flag update and checks for three things: the error pulse, a zero result, and a flag that still holds its earlier value.

// File: rtl/isc_pkg.sv
// Shared encodings for the set-compare unit.
// Assumes relation codes and merge codes are fixed by the instruction encoding.
package isc_pkg;

    typedef enum logic [2:0] {
        CMP_NEVER  = 3'd0,
        CMP_LT     = 3'd1,
        CMP_EQ     = 3'd2,
        CMP_LE     = 3'd3,
        CMP_GT     = 3'd4,
        CMP_NE     = 3'd5,
        CMP_GE     = 3'd6,
        CMP_ALWAYS = 3'd7
    } cmp_e;

    typedef enum logic [1:0] {
        MRG_AND = 2'd0,
        MRG_OR  = 2'd1,
        MRG_XOR = 2'd2,
        MRG_BAD = 2'd3
    } merge_e;

    // Map an ordering (less / equal) onto a relation code.
    function automatic logic pick_rel(input cmp_e op, input logic lt, input logic eq);
        logic gt;
        gt = !lt && !eq;
        case (op)
            CMP_NEVER:  pick_rel = 1'b0;
            CMP_LT:     pick_rel = lt;
            CMP_EQ:     pick_rel = eq;
            CMP_LE:     pick_rel = lt || eq;
            CMP_GT:     pick_rel = gt;
            CMP_NE:     pick_rel = !eq;
            CMP_GE:     pick_rel = !lt;
            default:    pick_rel = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/isc_plain_cmp.sv
// Plain-mode relation evaluator: signed or unsigned compare of a against b.
// Assumes purely combinational use; incoming chain flags are not consulted.
module isc_plain_cmp
    import isc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sgn,
    input  cmp_e              op,
    output logic              hit
);

    logic lt;
    logic eq;

    // Order the operands under the selected signedness.
    always_comb begin
        if (sgn) lt = $signed(a) < $signed(b);
        else     lt = a < b;
        eq  = (a == b);
        hit = pick_rel(op, lt, eq);
    end

endmodule

// File: rtl/isc_chain_cmp.sv
// Chained-mode relation evaluator for one slice of a wide compare.
// Assumes carry_in / zero_in were left by the lower-order slice of the same compare.
module isc_chain_cmp
    import isc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sgn,
    input  logic              carry_in,
    input  logic              zero_in,
    input  cmp_e              op,
    output logic              hit
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] diff;
    logic              neg;
    logic              dz;
    logic              flip;
    logic              lt_base;
    logic              gt_base;
    logic              ge_base;
    logic              eq_chain;
    logic              eq_broken;

    // Difference with borrow chained from the lower slice.
    always_comb begin
        diff = a + ~b + {{(DATA_W-1){1'b0}}, carry_in};
        neg  = diff[MSB];
        dz   = (diff == '0);
        flip = !sgn && (a[MSB] ^ b[MSB]);
    end

    // Base tests, swapped when unsigned operands disagree in their top bit.
    always_comb begin
        lt_base   = flip ? !neg        : neg;
        gt_base   = flip ? (neg || dz) : (!neg && !dz);
        ge_base   = flip ? neg         : !neg;
        eq_chain  = dz && zero_in;
        eq_broken = dz && !zero_in;
    end

    // Relation select.
    always_comb begin
        case (op)
            CMP_NEVER:  hit = 1'b0;
            CMP_LT:     hit = lt_base;
            CMP_EQ:     hit = eq_chain;
            CMP_LE:     hit = lt_base || eq_chain;
            CMP_GT:     hit = gt_base || eq_broken;
            CMP_NE:     hit = !dz || eq_broken;
            CMP_GE:     hit = ge_base || eq_chain;
            default:    hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/isc_merge.sv
// Merges the compare outcome with a predicate and encodes the result word.
// Assumes the caller rejects the reserved merge code via bad_sel.
module isc_merge
    import isc_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] FLOAT_ONE = 32'h3F80_0000
) (
    input  logic              cmp_hit,
    input  logic              pred_in,
    input  logic              pred_inv,
    input  merge_e            sel,
    input  logic              float_sel,
    output logic [DATA_W-1:0] value,
    output logic              bad_sel
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    logic pred_eff;
    logic pass;

    // Boolean merge of outcome and effective predicate.
    always_comb begin
        pred_eff = pred_in ^ pred_inv;
        bad_sel  = 1'b0;
        case (sel)
            MRG_AND: pass = cmp_hit & pred_eff;
            MRG_OR:  pass = cmp_hit | pred_eff;
            MRG_XOR: pass = cmp_hit ^ pred_eff;
            default: begin
                pass    = 1'b0;
                bad_sel = 1'b1;
            end
        endcase
    end

    // Result encoding: mask or float one on pass, zero otherwise.
    always_comb begin
        if (!pass)          value = '0;
        else if (float_sel) value = FLOAT_ONE;
        else                value = ALL_ONES;
    end

endmodule

// File: rtl/isc_set_cmp.sv
// Set-compare unit top: selects plain or chained compare, merges with the
// predicate, and registers result, zero flag and illegal-operation pulse.
// Assumes one operation per op_valid cycle; synchronous active-low reset.
module isc_set_cmp
    import isc_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] FLOAT_ONE = 32'h3F80_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [2:0]        cmp_sel,
    input  logic              is_signed,
    input  logic              chain_en,
    input  logic              carry_in,
    input  logic              zero_in,
    input  logic              pred_in,
    input  logic              pred_inv,
    input  logic [1:0]        bool_sel,
    input  logic              float_sel,
    input  logic              cc_en,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              zero_flag,
    output logic              err_illegal
);

    logic              hit_plain;
    logic              hit_chain;
    logic              hit;
    logic [DATA_W-1:0] value;
    logic              bad_sel;
    logic              illegal;

    isc_plain_cmp #(.DATA_W(DATA_W)) u_plain (
        .a   (src_a),
        .b   (src_b),
        .sgn (is_signed),
        .op  (cmp_e'(cmp_sel)),
        .hit (hit_plain)
    );

    isc_chain_cmp #(.DATA_W(DATA_W)) u_chain (
        .a        (src_a),
        .b        (src_b),
        .sgn      (is_signed),
        .carry_in (carry_in),
        .zero_in  (zero_in),
        .op       (cmp_e'(cmp_sel)),
        .hit      (hit_chain)
    );

    isc_merge #(.DATA_W(DATA_W), .FLOAT_ONE(FLOAT_ONE)) u_merge (
        .cmp_hit   (hit),
        .pred_in   (pred_in),
        .pred_inv  (pred_inv),
        .sel       (merge_e'(bool_sel)),
        .float_sel (float_sel),
        .value     (value),
        .bad_sel   (bad_sel)
    );

    // Mode select and illegal-combination detection.
    always_comb begin
        hit     = chain_en ? hit_chain : hit_plain;
        illegal = bad_sel || (cc_en && chain_en);
    end

    // Output registers: result, valid pulse, error pulse and zero flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_data    <= '0;
            zero_flag   <= 1'b0;
            err_illegal <= 1'b0;
        end else begin
            res_valid   <= op_valid;
            err_illegal <= op_valid && illegal;
            if (op_valid) begin
                res_data <= illegal ? '0 : value;
                if (cc_en && !illegal) zero_flag <= (value == '0);
            end
        end
    end

endmodule

// File: rtl/isc_set_cmp_chk.sv
// Protocol and encoding checks for the set-compare unit, bound to the top.
module isc_set_cmp_chk #(
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] FLOAT_ONE = 32'h3F80_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        cmp_sel,
    input logic              chain_en,
    input logic [1:0]        bool_sel,
    input logic              float_sel,
    input logic              cc_en,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic              zero_flag,
    input logic              err_illegal
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    p_never_and_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cmp_sel == 3'd0 && bool_sel == 2'd0) |=> (res_data == '0));

    p_result_encoding_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_data == '0 || res_data == ALL_ONES || res_data == FLOAT_ONE));

    p_float_form_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && float_sel) |=> (res_data != ALL_ONES));

    p_mask_form_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !float_sel) |=> (res_data != FLOAT_ONE));

    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !err_illegal));

    p_flag_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cc_en && !chain_en && bool_sel != 2'd3) |=> (zero_flag == (res_data == '0)));

    p_flag_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && cc_en) |=> $stable(zero_flag));

    p_illegal_flagged_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (bool_sel == 2'd3 || (cc_en && chain_en))) |=> (err_illegal && res_data == '0));

    p_illegal_keeps_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_illegal |-> $stable(zero_flag));

    p_error_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_illegal |-> res_valid);

endmodule

bind isc_set_cmp isc_set_cmp_chk #(.DATA_W(DATA_W), .FLOAT_ONE(FLOAT_ONE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .cmp_sel     (cmp_sel),
    .chain_en    (chain_en),
    .bool_sel    (bool_sel),
    .float_sel   (float_sel),
    .cc_en       (cc_en),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .zero_flag   (zero_flag),
    .err_illegal (err_illegal)
);

// File: tb/isc_set_cmp_tb.sv
// Scoreboard bench: the driver predicts each result into a queue; the monitor
// pops and compares on every res_valid.
module isc_set_cmp_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [2:0]  cmp_sel = '0;
    logic        is_signed = 1'b0;
    logic        chain_en = 1'b0;
    logic        carry_in = 1'b0;
    logic        zero_in = 1'b0;
    logic        pred_in = 1'b0;
    logic        pred_inv = 1'b0;
    logic [1:0]  bool_sel = '0;
    logic        float_sel = 1'b0;
    logic        cc_en = 1'b0;
    logic        res_valid;
    logic [31:0] res_data;
    logic        zero_flag;
    logic        err_illegal;

    typedef struct {
        logic [31:0] data;
        logic        err;
        logic        zf;
        string       tag;
    } exp_t;

    exp_t   sb[$];
    int     checks = 0;
    int     fails = 0;
    logic   zf_model = 1'b0;
    logic   done = 1'b0;

    always #4 clk = ~clk;

    isc_set_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .src_a(src_a), .src_b(src_b),
        .cmp_sel(cmp_sel), .is_signed(is_signed), .chain_en(chain_en), .carry_in(carry_in),
        .zero_in(zero_in), .pred_in(pred_in), .pred_inv(pred_inv), .bool_sel(bool_sel),
        .float_sel(float_sel), .cc_en(cc_en), .res_valid(res_valid), .res_data(res_data),
        .zero_flag(zero_flag), .err_illegal(err_illegal)
    );

    // Reference relation from the requirement text (R1..R4).
    function automatic logic ref_rel(input logic [31:0] a, input logic [31:0] b,
                                     input logic [2:0] op, input logic sg,
                                     input logic ch, input logic c, input logic z);
        logic [31:0] d;
        logic signed [31:0] sd;
        logic lt, eq, fl, lb;
        if (!ch) begin
            lt = sg ? ($signed(a) < $signed(b)) : (a < b);
            eq = (a == b);
            case (op)
                3'd0: return 1'b0;
                3'd1: return lt;
                3'd2: return eq;
                3'd3: return lt | eq;
                3'd4: return !(lt | eq);
                3'd5: return !eq;
                3'd6: return !lt;
                default: return 1'b1;
            endcase
        end
        d  = a + ~b + {31'd0, c};
        sd = d;
        fl = sg ? 1'b0 : (a[31] ^ b[31]);
        lb = fl ? (sd >= 0) : (sd < 0);
        case (op)
            3'd0: return 1'b0;
            3'd1: return lb;
            3'd2: return (d == 0) && z;
            3'd3: return lb || ((d == 0) && z);
            3'd4: return (fl ? (sd <= 0) : (sd > 0)) || ((d == 0) && !z);
            3'd5: return (d != 0) || ((d == 0) && !z);
            3'd6: return (fl ? (sd < 0) : (sd >= 0)) || ((d == 0) && z);
            default: return 1'b1;
        endcase
    endfunction

    // Driver: present one operation and push its predicted outcome.
    task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op,
                        input logic sg, input logic ch, input logic c, input logic z,
                        input logic p, input logic pinv, input logic [1:0] bs,
                        input logic fs, input logic cc, input string tag);
        exp_t e;
        logic hit, pe, pass, bad;
        logic [31:0] val;
        @(posedge clk);
        #1;
        op_valid = 1'b1; src_a = a; src_b = b; cmp_sel = op; is_signed = sg;
        chain_en = ch; carry_in = c; zero_in = z; pred_in = p; pred_inv = pinv;
        bool_sel = bs; float_sel = fs; cc_en = cc;
        hit  = ref_rel(a, b, op, sg, ch, c, z);
        pe   = pinv ? !p : p;
        pass = (bs == 2'd0) ? (hit && pe) : (bs == 2'd1) ? (hit || pe) : (hit != pe);
        bad  = (bs == 2'd3) || (cc && ch);
        val  = (!pass || bad) ? 32'h0 : (fs ? 32'h3F80_0000 : 32'hFFFF_FFFF);
        if (cc && !bad) zf_model = (val == 32'h0);
        e.data = val; e.err = bad; e.zf = zf_model; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            op_valid = 1'b0;
        end
    endtask

    // Monitor: compare each produced result against the queue head.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && res_valid && !done) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R7 unexpected res_valid actual=1 expected=0");
            end else begin
                e = sb.pop_front();
                if (res_data !== e.data || err_illegal !== e.err || zero_flag !== e.zf) begin
                    fails++;
                    $display("FAIL %s data/err/zf actual=%h/%b/%b expected=%h/%b/%b",
                             e.tag, res_data, err_illegal, zero_flag, e.data, e.err, e.zf);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] va [6];
        va[0] = 32'd5; va[1] = 32'd9; va[2] = 32'h8000_0000;
        va[3] = 32'h7FFF_FFFF; va[4] = 32'hFFFF_FFFF; va[5] = 32'd0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;   // R10 reset state
        if (res_valid !== 1'b0 || res_data !== 32'h0 || zero_flag !== 1'b0 || err_illegal !== 1'b0) begin
            fails++;
            $display("FAIL R10 reset actual=%b/%h/%b/%b expected=0/0/0/0",
                     res_valid, res_data, zero_flag, err_illegal);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 plain mode, every code, signed and unsigned, chain flags toggled to prove they are ignored.
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
                for (int op = 0; op < 8; op++)
                    send(va[i], va[j], 3'(op), 1'((i + op) % 2), 1'b0, 1'(j % 2), 1'(op % 2),
                         1'b1, 1'b0, 2'd0, 1'b0, 1'b0, "R1");
        idle(2);

        // R2/R3/R4 chained mode across carry and zero flag combinations.
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
                for (int op = 1; op < 7; op++)
                    for (int cz = 0; cz < 4; cz++)
                        send(va[i], va[j], 3'(op), 1'(cz % 2 ^ i % 2), 1'b1, cz[0], cz[1],
                             1'b1, 1'b0, 2'd0, 1'b0, 1'b0,
                             (op == 1) ? "R2" : (op == 2 || op == 5) ? "R3" : "R4");

        // R3 64-bit equality chained from low slice (C=1, Z=1) and broken low slice (Z=0).
        send(32'h1234_5678, 32'h1234_5678, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, "R3");
        send(32'h1234_5678, 32'h1234_5678, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, "R3");
        // R2 unsigned high slice 1 < 2 with no borrow.
        send(32'd1, 32'd2, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, "R2");
        idle(1);

        // R5 predicate merge and negate, every combination.
        for (int k = 0; k < 24; k++)
            send(32'd3, 32'd3, (k % 2) ? 3'd2 : 3'd5, 1'b0, 1'b0, 1'b0, 1'b0,
                 k[1], k[2], 2'(k / 8), 1'b0, 1'b0, "R5");

        // R6 float and mask encodings.
        send(32'd1, 32'd2, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, "R6");
        send(32'd1, 32'd2, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, "R6");
        send(32'd1, 32'd2, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, "R6");

        // R8 flag refresh coinciding with true and false results, then holds.
        send(32'd4, 32'd4, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, "R8");
        send(32'd4, 32'd5, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, "R8");
        send(32'd4, 32'd4, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, "R8");
        send(32'd4, 32'd4, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, "R8");

        // R9 illegal combinations right after a flag update: flag must hold.
        send(32'd4, 32'd4, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, "R9");
        send(32'd4, 32'd4, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 1'b1, "R9");
        send(32'd4, 32'd9, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, "R8");
        send(32'd4, 32'd4, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1, "R9");
        idle(3);

        // Mixed traffic with gaps (R7) and random fields.
        for (int k = 0; k < 400; k++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = ($urandom % 4 == 0) ? ra : $urandom;
            send(ra, rb, 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), "R7");
            if (k % 7 == 0) idle(1);
        end
        idle(3);

        checks++;   // R7 every issued operation produced exactly one result
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R7 pending results actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule